// File: doc/BRIEF.md
# Indirect PHY Control-Register Bridge

This block is a memory-mapped slave that gives software access to the 16-bit control registers inside a high-speed serial PHY. It does not use a direct address/data bus. Software stages a value in a data-in register and then sets a command bit. The bridge turns that command into a one-cycle strobe on the PHY control port and then waits for the PHY to acknowledge.

A PHY register write takes three commands: capture the address, capture the data, then commit the write. A read takes two: capture the address, then issue the read. After the read command clears, the result is in the data-out register. Each command bit reads back as 1 while its operation is pending and clears itself when the PHY acknowledges. Software polls that bit, at most ten times spaced roughly 10 to 20 µs apart, so every operation must finish well inside about 100 µs.

PHY addresses are 16 bits wide. Per-lane registers repeat at a stride of 0x100 per lane, for example 0x1002 and 0x1006 for lane 0.

The control sequencer is a three-state machine:
- **IDLE**: nothing is pending.
- **ISSUE**: the strobe is driven for exactly one cycle.
- **WAIT**: the bridge holds until the acknowledge arrives.

Its transitions are:
- **ACCEPT** (IDLE→ISSUE): a valid command is written while idle.
- **FAST_DONE** (ISSUE→IDLE): the acknowledge is already present in the strobe cycle.
- **HOLD** (ISSUE→WAIT): no acknowledge is present in the strobe cycle.
- **DONE** (WAIT→IDLE): the acknowledge arrives.

Top module: `phycr_bridge`

## Requirements
- R1: After reset, every register reads 0 and no PHY strobe is active. The registers are data-in (0x0C), data-out (0x10), capture-address (0x14), capture-data (0x18), read (0x1C) and write (0x20).
- R2: A bus write to 0x0C stores bits 15:0 of the write data. Offset 0x0C reads back that value, zero-extended.
- R3: A bus write of a value with bit 0 set to a command offset, made while idle, is accepted. The accepted command produces exactly one strobe of the matching kind, in the cycle after the write: 0x14→phy_cap_addr, 0x18→phy_cap_data, 0x1C→phy_rd, 0x20→phy_wr. During the strobe, phy_wdata equals the data-in value held at the write.
- R4: Bit 0 of the accepted command's register reads 1 from the cycle after the write. It clears at the first clock edge at which phy_ack is sampled high. The other command registers read 0 throughout.
- R5: Data-out loads phy_rdata at the acknowledge of a read. It holds its value at every other edge, including the acknowledge of any other command.
- R6: A command written while another is pending is ignored. The pending command's kind and bit stay unchanged, and no extra strobe appears.
- R7: A write to a command offset with bit 0 clear has no effect: no strobe is produced and the command bit stays 0.
- R8: phy_ack may arrive any number of cycles, one or more, after the strobe. phy_ack is ignored while nothing is pending.
- R9: At most one PHY strobe is active in any cycle.
- R10: Two back-to-back reads of the same PHY address return identical values in data-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Bus write enable |
| bus_addr | input | ADDR_W (8) | Byte offset for reads and writes |
| bus_wdata | input | DATA_W (32) | Bus write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr (combinational) |
| phy_wdata | output | CR_W (16) | Address or data value presented to the PHY |
| phy_cap_addr | output | 1 | One-cycle strobe: PHY captures an address |
| phy_cap_data | output | 1 | One-cycle strobe: PHY captures data |
| phy_rd | output | 1 | One-cycle strobe: PHY performs a read |
| phy_wr | output | 1 | One-cycle strobe: PHY performs a write |
| phy_ack | input | 1 | PHY acknowledges the pending operation |
| phy_rdata | input | CR_W (16) | PHY read result, valid while phy_ack is high |

## Verification
The embedded assertions check a set of properties every cycle:
- the strobes are mutually exclusive and last one cycle;
- the bridge stays busy until the acknowledge and always releases on it;
- the pending command's kind and data are held while a new command arrives;
- data-out changes only on a read acknowledge.

Only the bench scenarios can show the end-to-end behaviour:
- PHY registers written through the three-command sequence can be read back;
- the acknowledge latency varies;
- a command written while busy never reaches the PHY;
- a stray acknowledge leaves data-out intact;
- repeated reads agree.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

    typedef enum logic [1:0] {
        CMD_CAP_ADDR = 2'd0,
        CMD_CAP_DATA = 2'd1,
        CMD_READ     = 2'd2,
        CMD_WRITE    = 2'd3
    } cr_cmd_e;

    localparam int NUM_CMDS = 4;

    localparam int unsigned OFS_DIN  = 32'h0C;
    localparam int unsigned OFS_DOUT = 32'h10;
    localparam int unsigned OFS_CAPA = 32'h14;
    localparam int unsigned OFS_CAPD = 32'h18;
    localparam int unsigned OFS_RD   = 32'h1C;
    localparam int unsigned OFS_WR   = 32'h20;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/phycr_regs.sv
module phycr_regs
    import phycr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  cr_cmd_e           cur_kind,
    input  logic              load_dout,
    input  logic [CR_W-1:0]   phy_rdata,
    output logic [CR_W-1:0]   din_q,
    output logic              cmd_go,
    output cr_cmd_e           cmd_kind
);

    localparam int PAD_W = 32 - ADDR_W;
    localparam int ZX_W  = DATA_W - CR_W;

    logic [31:0]     ofs;
    logic            cmd_hit;
    logic [CR_W-1:0] dout_q;

    assign ofs = {{PAD_W{1'b0}}, bus_addr};

    always_comb begin
        cmd_hit  = 1'b1;
        cmd_kind = CMD_CAP_ADDR;
        if (ofs == OFS_CAPA) begin
            cmd_kind = CMD_CAP_ADDR;
        end else if (ofs == OFS_CAPD) begin
            cmd_kind = CMD_CAP_DATA;
        end else if (ofs == OFS_RD) begin
            cmd_kind = CMD_READ;
        end else if (ofs == OFS_WR) begin
            cmd_kind = CMD_WRITE;
        end else begin
            cmd_hit = 1'b0;
        end
    end

    assign cmd_go = bus_wr_en && cmd_hit && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
        end else if (bus_wr_en && ofs == OFS_DIN) begin
            din_q <= bus_wdata[CR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (load_dout) begin
            dout_q <= phy_rdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (ofs == OFS_DIN) begin
            bus_rdata = {{ZX_W{1'b0}}, din_q};
        end else if (ofs == OFS_DOUT) begin
            bus_rdata = {{ZX_W{1'b0}}, dout_q};
        end else if (cmd_hit) begin
            bus_rdata[0] = busy && (cur_kind == cmd_kind);
        end
    end

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_dout |=> $stable(dout_q)); // R5
    AST_DOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_dout |=> dout_q == $past(phy_rdata)); // R5

endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
    import phycr_pkg::*;
#(
    parameter int CR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_go,
    input  cr_cmd_e             cmd_kind,
    input  logic [CR_W-1:0]     din_q,
    input  logic                phy_ack,
    output logic                busy,
    output cr_cmd_e             cur_kind,
    output logic [CR_W-1:0]     phy_wdata,
    output logic [NUM_CMDS-1:0] strb,
    output logic                load_dout
);

    seq_state_e state, state_nx;
    logic       accept;
    logic       done;

    assign accept = (state == S_IDLE) && cmd_go;
    assign done   = (state != S_IDLE) && phy_ack;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (cmd_go)  state_nx = S_ISSUE;
            S_ISSUE: state_nx = phy_ack ? S_IDLE : S_WAIT;
            S_WAIT:  if (phy_ack) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind  <= CMD_CAP_ADDR;
            phy_wdata <= '0;
        end else if (accept) begin
            cur_kind  <= cmd_kind;
            phy_wdata <= din_q;
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        load_dout = done && (cur_kind == CMD_READ);
    end

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_strb
        assign strb[g] = (state == S_ISSUE) && (cur_kind == cr_cmd_e'(g));
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb)); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|strb) |=> !(|strb)); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !phy_ack |=> busy); // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phy_ack |=> !busy); // R4
    AST_KIND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !phy_ack |=> $stable(cur_kind) && $stable(phy_wdata)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !cmd_go |=> !(|strb)); // R7

endmodule

// File: rtl/phycr_bridge.sv
module phycr_bridge
    import phycr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CR_W-1:0]   phy_wdata,
    output logic              phy_cap_addr,
    output logic              phy_cap_data,
    output logic              phy_rd,
    output logic              phy_wr,
    input  logic              phy_ack,
    input  logic [CR_W-1:0]   phy_rdata
);

    logic                busy;
    cr_cmd_e             cur_kind;
    cr_cmd_e             cmd_kind;
    logic                cmd_go;
    logic                load_dout;
    logic [CR_W-1:0]     din_q;
    logic [NUM_CMDS-1:0] strb;

    phycr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CR_W(CR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .cur_kind  (cur_kind),
        .load_dout (load_dout),
        .phy_rdata (phy_rdata),
        .din_q     (din_q),
        .cmd_go    (cmd_go),
        .cmd_kind  (cmd_kind)
    );

    phycr_seq #(.CR_W(CR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_kind  (cmd_kind),
        .din_q     (din_q),
        .phy_ack   (phy_ack),
        .busy      (busy),
        .cur_kind  (cur_kind),
        .phy_wdata (phy_wdata),
        .strb      (strb),
        .load_dout (load_dout)
    );

    assign phy_cap_addr = strb[CMD_CAP_ADDR];
    assign phy_cap_data = strb[CMD_CAP_DATA];
    assign phy_rd       = strb[CMD_READ];
    assign phy_wr       = strb[CMD_WRITE];

endmodule

// File: tb/tb_phycr_bridge.sv
module tb_phycr_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [15:0] phy_wdata;
    logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic        phy_ack;
    logic [15:0] phy_rdata;

    always #5 clk = ~clk;

    phycr_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phy_wdata(phy_wdata),
        .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural PHY register array ----------------
    logic [15:0] phy_mem [int];
    int          ack_lat = 1;
    int          ack_cnt = 0;
    logic        ack_r = 1'b0;
    logic [15:0] rd_r = 16'h0;
    logic        stray = 1'b0;
    logic [15:0] cap_a = 16'h0;
    logic [15:0] cap_d = 16'h0;

    assign phy_ack   = ack_r | stray;
    assign phy_rdata = stray ? 16'hDEAD : rd_r;

    always @(negedge clk) begin
        ack_r <= 1'b0;
        if (ack_cnt > 0) begin
            ack_cnt <= ack_cnt - 1;
            if (ack_cnt == 1) ack_r <= 1'b1;
        end
        if (phy_cap_addr || phy_cap_data || phy_rd || phy_wr) begin
            if (phy_cap_addr) cap_a <= phy_wdata;
            if (phy_cap_data) cap_d <= phy_wdata;
            if (phy_wr) phy_mem[int'(cap_a)] = cap_d;
            if (phy_rd) rd_r <= phy_mem.exists(int'(cap_a)) ? phy_mem[int'(cap_a)] : 16'h0;
            if (ack_lat <= 1) ack_r <= 1'b1;
            else ack_cnt <= ack_lat - 1;
        end
    end

    // ---------------- cycle-level reference model ----------------
    bit          m_busy = 0;
    int          m_kind = 0;
    bit          m_strobe = 0;
    logic [15:0] m_sdata = 0;
    logic [15:0] m_din = 0;
    logic [15:0] m_dout = 0;

    function automatic int cmd_of(input logic [7:0] a);
        case (a)
            8'h14: return 0;
            8'h18: return 1;
            8'h1C: return 2;
            8'h20: return 3;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_kind = 0; m_strobe = 0; m_sdata = 0; m_din = 0; m_dout = 0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            m_strobe = 0;
            if (was_busy && phy_ack) begin
                m_busy = 0;
                if (m_kind == 2) m_dout = phy_rdata;
            end else if (!was_busy && bus_wr_en && cmd_of(bus_addr) >= 0 && bus_wdata[0]) begin
                m_busy = 1; m_kind = cmd_of(bus_addr); m_strobe = 1; m_sdata = m_din;
            end
            if (bus_wr_en && bus_addr == 8'h0C) m_din = bus_wdata[15:0];
        end
    end

    // every-cycle comparison of the PHY strobes (R3, R6, R7, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] act, exp;
            act = {phy_wr, phy_rd, phy_cap_data, phy_cap_addr};
            exp = m_strobe ? (4'b0001 << m_kind) : 4'b0000;
            check(act == exp, "R3/R6/R7/R9 strobe vector", int'(act), int'(exp));
            if (m_strobe)
                check(phy_wdata == m_sdata, "R3 phy_wdata", int'(phy_wdata), int'(m_sdata));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, int'(bus_rdata), int'(exp));
    endtask

    task automatic poll(input logic [7:0] a);
        bit cleared;
        cleared = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bus_addr = a;
            #1;
            if (bus_rdata[0] == 1'b0) begin
                cleared = 1;
                break;
            end
        end
        check(cleared, "R4 command bit clears after ack", int'(bus_rdata[0]), 0);
    endtask

    task automatic run_cmd(input logic [7:0] a);
        bus_write(a, 32'h1);
        read_chk(a, 32'h1, "R4 busy bit set after accept");
        poll(a);
    endtask

    logic [15:0] exp_mem [int];

    task automatic phy_write(input logic [15:0] ra, input logic [15:0] rv, input int lat);
        ack_lat = lat;
        bus_write(8'h0C, {16'h0, ra});
        run_cmd(8'h14);
        bus_write(8'h0C, {16'hFFFF, rv});
        run_cmd(8'h18);
        run_cmd(8'h20);
        exp_mem[int'(ra)] = rv;
    endtask

    task automatic phy_read(input logic [15:0] ra, input int lat);
        ack_lat = lat;
        bus_write(8'h0C, {16'h0, ra});
        run_cmd(8'h14);
        run_cmd(8'h1C);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk(8'h0C, 0, "R1 data-in reset");
        read_chk(8'h10, 0, "R1 data-out reset");
        read_chk(8'h14, 0, "R1 cap-addr bit reset");
        read_chk(8'h18, 0, "R1 cap-data bit reset");
        read_chk(8'h1C, 0, "R1 read bit reset");
        read_chk(8'h20, 0, "R1 write bit reset");

        // R2: data-in keeps low 16 bits
        bus_write(8'h0C, 32'h1234ABCD);
        read_chk(8'h0C, 32'h0000ABCD, "R2 data-in readback");

        // R4: other command bits stay 0 while one is pending
        ack_lat = 4;
        bus_write(8'h14, 32'h1);
        read_chk(8'h14, 1, "R4 cap-addr busy");
        read_chk(8'h1C, 0, "R4 read bit idle while cap-addr pending");
        read_chk(8'h20, 0, "R4 write bit idle while cap-addr pending");
        poll(8'h14);

        // R3, R8: writes at varied latency
        phy_write(16'h1006, 16'h3C5A, 1);
        phy_write(16'h1002, 16'h6E80, 3);
        phy_write(16'h1106, 16'h0F0F, 7);
        read_chk(8'h10, 0, "R5 data-out untouched by write acks");

        // R5: reads return what was written
        phy_read(16'h1002, 2);
        read_chk(8'h10, {16'h0, exp_mem[32'h1002]}, "R5 read lane0 0x1002");
        phy_read(16'h1106, 5);
        read_chk(8'h10, {16'h0, exp_mem[32'h1106]}, "R5 read lane1 0x1106");

        // R10: back-to-back reads agree
        phy_read(16'h1006, 1);
        first = bus_rdata;
        bus_addr = 8'h10; #1; first = bus_rdata;
        phy_read(16'h1006, 6);
        read_chk(8'h10, first, "R10 second read equals first");
        read_chk(8'h10, {16'h0, exp_mem[32'h1006]}, "R10 value correct");

        // R6: commands during a pending read are ignored
        ack_lat = 1;
        bus_write(8'h0C, 32'h1002);
        run_cmd(8'h14);
        ack_lat = 12;
        bus_write(8'h1C, 32'h1);
        bus_write(8'h20, 32'h1);
        read_chk(8'h20, 0, "R6 write bit stays 0 while read pending");
        read_chk(8'h1C, 1, "R6 read bit still pending");
        bus_write(8'h0C, 32'h1106);
        bus_write(8'h14, 32'h1);
        read_chk(8'h14, 0, "R6 cap-addr ignored while busy");
        poll(8'h1C);
        read_chk(8'h10, {16'h0, exp_mem[32'h1002]}, "R6 pending read result intact");
        phy_read(16'h1002, 2);
        read_chk(8'h10, {16'h0, exp_mem[32'h1002]}, "R6 ignored write never committed");

        // R7: command writes with bit 0 clear
        bus_write(8'h1C, 32'h0);
        read_chk(8'h1C, 0, "R7 read bit stays 0");
        bus_write(8'h20, 32'hFFFFFFFE);
        read_chk(8'h20, 0, "R7 write bit stays 0");
        repeat (3) @(negedge clk);
        read_chk(8'h10, {16'h0, exp_mem[32'h1002]}, "R7 data-out unchanged");

        // R8: stray acknowledge while idle
        @(negedge clk);
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        read_chk(8'h10, {16'h0, exp_mem[32'h1002]}, "R8 stray ack ignored");
        read_chk(8'h10, {16'h0, m_dout}, "R5 model data-out agrees");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule